// File: doc/BRIEF.md
# In-Band Controlled Constellation Mapper

This block turns a stream of small bit groups into I/Q constellation points for an OFDM transmitter. Its single input stream carries two kinds of word: data words holding up to four bits, and control tokens. One kind of control token picks the modulation. That choice then applies to every data word that follows it, until another such token arrives. Because the choice travels inside the stream, a change lands exactly on the data it precedes. This holds even in the middle of a packet, so unequal error protection can switch modulation many times per packet.

The block consumes modulation tokens. It does not act on any other token and hands each one to the output unchanged, in its original place among the points. Both edges use a valid/ready handshake, and a two-entry output buffer separates the two sides. The block therefore makes no assumption about how many cycles its neighbours take.

Top module: `inband_mapper`

## Requirements
- R1: After reset, out_valid and err_o are 0, in_ready is 1, and the modulation in force is BPSK.
- R2: A word with in_is_ctrl=0 is data: in_word[3:0] holds the bits, with bit 0 sent first, and in_word[6:4] holds the count of valid bits. A word with in_is_ctrl=1 is a token. A token with in_word[7:6]=2'b10 and in_word[1:0] set to 00 (BPSK), 01 (QPSK) or 10 (16-QAM) is a modulation token. It is consumed and produces no output. Any other token, including code 11, leaves the modulation unchanged.
- R3: BPSK maps bit 0 to I: a 0 gives -64 and a 1 gives +64. Q is 0.
- R4: QPSK maps bit 0 to I and bit 1 to Q. A 0 gives -45 and a 1 gives +45.
- R5: 16-QAM takes bit 0 and bit 1 for I, and bit 2 and bit 3 for Q. Each pair (first, second) maps as follows: 00 gives -63, 01 gives -21, 11 gives +21 and 10 gives +63.
- R6: A modulation token affects only data words accepted after it. Words accepted before it keep the old mapping, even when the token falls inside a burst.
- R7: A token that is not a modulation token appears on the output with out_is_tok=1, out_tok equal to its word, and out_i and out_q equal to 0. It keeps its order relative to the points.
- R8: A transfer happens only when valid and ready are both high. While out_valid is high and out_ready is low, all output fields hold steady. No item is lost or repeated under any pattern of backpressure.
- R9: in_ready falls only while two items are buffered. When the buffer is empty, an accepted word shows on the output in the cycle after it is accepted.
- R10: A data word whose count differs from the bits needed by the current modulation (1, 2 or 4) sets err_o, and err_o stays high until reset. Such a word is still mapped from its low bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept a word |
| in_is_ctrl | input | 1 | 1: word is a token, 0: word is data |
| in_word | input | 8 | Data bits and count, or token |
| out_valid | output | 1 | Output item valid |
| out_ready | input | 1 | Downstream accepts the item |
| out_is_tok | output | 1 | 1: item is a forwarded token |
| out_i | output | SW | In-phase value, signed |
| out_q | output | SW | Quadrature value, signed |
| out_tok | output | 8 | Forwarded token word |
| err_o | output | 1 | Sticky bit-count mismatch flag |

## Verification
A stale or wrong modulation register shows at the ports on the very next data word. That word comes out with the amplitude or axis assignment of another modulation one cycle after it is accepted. The tests place modulation tokens right before, between and right after data words to catch a change that lands one word early or late. A buffer pointer or count fault shows up in one of three ways: a repeated, lost or reordered item, output fields that change during a stall, or in_ready dropping early. Random backpressure and a deliberate two-deep stall bring each of these out within a few cycles.

// File: rtl/inband_map_pkg.sv
package inband_map_pkg;

  localparam int WORD_W = 8;
  localparam int BITS_W = 4;
  localparam int CNT_W  = 3;

  typedef enum logic [1:0] {
    MOD_BPSK  = 2'b00,
    MOD_QPSK  = 2'b01,
    MOD_QAM16 = 2'b10
  } mod_e;

  // token class that selects a modulation
  localparam logic [1:0] TOK_CLASS_MOD = 2'b10;

  function automatic logic [CNT_W-1:0] bits_for(input mod_e m);
    case (m)
      MOD_BPSK:  bits_for = CNT_W'(1);
      MOD_QPSK:  bits_for = CNT_W'(2);
      MOD_QAM16: bits_for = CNT_W'(4);
      default:   bits_for = CNT_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/inband_map_dec.sv
module inband_map_dec
  import inband_map_pkg::*;
(
  input  logic              is_ctrl,
  input  logic [WORD_W-1:0] word,
  output logic              is_mod_tok,
  output mod_e              mod_sel,
  output logic [BITS_W-1:0] data_bits,
  output logic [CNT_W-1:0]  data_cnt
);

  logic [1:0] code;

  always_comb begin
    code       = word[1:0];
    is_mod_tok = is_ctrl && (word[7:6] == TOK_CLASS_MOD) && (code != 2'b11);
    mod_sel    = mod_e'(code);
    data_bits  = word[BITS_W-1:0];
    data_cnt   = word[BITS_W +: CNT_W];
  end

endmodule

// File: rtl/inband_map_const.sv
module inband_map_const
  import inband_map_pkg::*;
#(
  parameter int SW       = 8,
  parameter int AMP_BPSK = 64,
  parameter int AMP_QPSK = 45,
  parameter int AMP_QAM  = 21
) (
  input  mod_e                   mode,
  input  logic [BITS_W-1:0]      bits,
  output logic signed [SW-1:0]   pt_i,
  output logic signed [SW-1:0]   pt_q
);

  localparam logic signed [SW-1:0] LV_B  = SW'(AMP_BPSK);
  localparam logic signed [SW-1:0] LV_Q  = SW'(AMP_QPSK);
  localparam logic signed [SW-1:0] LV_IN = SW'(AMP_QAM);
  localparam logic signed [SW-1:0] LV_OU = SW'(3 * AMP_QAM);

  // Gray pair: first bit gives sign, second bit picks the inner ring
  function automatic logic signed [SW-1:0] qam_axis(input logic b_sign, input logic b_inner);
    logic signed [SW-1:0] mag;
    mag = b_inner ? LV_IN : LV_OU;
    qam_axis = b_sign ? mag : -mag;
  endfunction

  always_comb begin
    pt_i = '0;
    pt_q = '0;
    case (mode)
      MOD_BPSK: begin
        pt_i = bits[0] ? LV_B : -LV_B;
      end
      MOD_QPSK: begin
        pt_i = bits[0] ? LV_Q : -LV_Q;
        pt_q = bits[1] ? LV_Q : -LV_Q;
      end
      MOD_QAM16: begin
        pt_i = qam_axis(bits[0], bits[1]);
        pt_q = qam_axis(bits[2], bits[3]);
      end
      default: begin
        pt_i = '0;
        pt_q = '0;
      end
    endcase
  end

endmodule

// File: rtl/inband_map_skid.sv
module inband_map_skid #(
  parameter int W     = 25,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop_ready,
  output logic         out_valid,
  output logic [W-1:0] dout
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_pop;

  always_comb begin
    full      = (cnt_q == CAP);
    out_valid = (cnt_q != '0);
    do_pop    = out_valid && pop_ready;
    dout      = mem[rd_q];
    wr_d      = push   ? ((wr_q == LAST) ? '0 : wr_q + PW'(1)) : wr_q;
    rd_d      = do_pop ? ((rd_q == LAST) ? '0 : rd_q + PW'(1)) : rd_q;
    cnt_d     = cnt_q + CW'(push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic we;
    assign we = push && (wr_q == PW'(g));
    always_ff @(posedge clk) begin
      if (we) mem[g] <= din;
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !pop_ready |=> out_valid && $stable(dout));

endmodule

// File: rtl/inband_mapper.sv
module inband_mapper
  import inband_map_pkg::*;
#(
  parameter int SW       = 8,
  parameter int DEPTH    = 2,
  parameter int AMP_BPSK = 64,
  parameter int AMP_QPSK = 45,
  parameter int AMP_QAM  = 21
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_is_ctrl,
  input  logic [WORD_W-1:0]    in_word,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_is_tok,
  output logic signed [SW-1:0] out_i,
  output logic signed [SW-1:0] out_q,
  output logic [WORD_W-1:0]    out_tok,
  output logic                 err_o
);

  localparam int EW = 1 + WORD_W + 2 * SW;

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_n;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= '0;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n = rst_pipe[1];

  logic              is_mod_tok;
  mod_e              dec_mode;
  logic [BITS_W-1:0] data_bits;
  logic [CNT_W-1:0]  data_cnt;

  inband_map_dec u_dec (
    .is_ctrl    (in_is_ctrl),
    .word       (in_word),
    .is_mod_tok (is_mod_tok),
    .mod_sel    (dec_mode),
    .data_bits  (data_bits),
    .data_cnt   (data_cnt)
  );

  mod_e                 mode_q, mode_d;
  logic                 err_q, err_d;
  logic signed [SW-1:0] pt_i, pt_q;

  inband_map_const #(
    .SW       (SW),
    .AMP_BPSK (AMP_BPSK),
    .AMP_QPSK (AMP_QPSK),
    .AMP_QAM  (AMP_QAM)
  ) u_const (
    .mode (mode_q),
    .bits (data_bits),
    .pt_i (pt_i),
    .pt_q (pt_q)
  );

  logic          full, accept, mode_en, push;
  logic [EW-1:0] entry, head;

  always_comb begin
    in_ready = !full;
    accept   = in_valid && in_ready;
    mode_en  = accept && is_mod_tok;
    push     = accept && !is_mod_tok;
    mode_d   = dec_mode;
    err_d    = err_q || (accept && !in_is_ctrl && (data_cnt != bits_for(mode_q)));
    if (in_is_ctrl) entry = {1'b1, in_word, {(2 * SW){1'b0}}};
    else            entry = {1'b0, {WORD_W{1'b0}}, pt_i, pt_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MOD_BPSK;
      err_q  <= 1'b0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      err_q <= err_d;
    end
  end

  inband_map_skid #(.W(EW), .DEPTH(DEPTH)) u_skid (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .din       (entry),
    .full      (full),
    .pop_ready (out_ready),
    .out_valid (out_valid),
    .dout      (head)
  );

  always_comb begin
    out_is_tok = head[EW-1];
    out_tok    = head[2*SW +: WORD_W];
    out_i      = head[SW +: SW];
    out_q      = head[0 +: SW];
    err_o      = err_q;
  end

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  assert_ready_when_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid);

  assert_tok_no_point_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_tok |-> (out_i == '0) && (out_q == '0));

  assert_mod_tok_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && mode_en |=> !out_valid);

endmodule

// File: tb/inband_mapper_tb_top.sv
`timescale 1ns/1ps
module inband_mapper_tb_top;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0;
  logic in_is_ctrl = 1'b0;
  logic [7:0] in_word = '0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_is_tok, err_o;
  logic signed [7:0] out_i, out_q;
  logic [7:0] out_tok;

  always #2.5 clk = ~clk;

  inband_mapper dut_i (
    .clk(clk), .rst_ni(rst_ni),
    .in_valid(in_valid), .in_ready(in_ready), .in_is_ctrl(in_is_ctrl), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_is_tok(out_is_tok),
    .out_i(out_i), .out_q(out_q), .out_tok(out_tok), .err_o(err_o)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  bit mon_en = 0;

  // expected output queue
  bit    e_tok [0:1023];
  int    e_i   [0:1023];
  int    e_q   [0:1023];
  int    e_w   [0:1023];
  string e_req [0:1023];
  int    wr = 0;
  int    rd = 0;
  int    tb_mode = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int qlev(input bit s, input bit inner);
    int m;
    m = inner ? 21 : 63;
    return s ? m : -m;
  endfunction

  // backpressure source
  bit bp_en = 0;
  bit hold_rdy = 1;
  logic [7:0] lfsr = 8'h5a;
  always begin
    @(posedge clk);
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = bp_en ? lfsr[0] : hold_rdy;
  end

  // monitor: compares transfers, and stall stability (R8)
  bit stall_prev = 0;
  logic [24:0] saved;
  always @(negedge clk) begin
    if (mon_en) begin
      if (stall_prev)
        chk(out_valid && ({out_is_tok, out_tok, out_i, out_q} === saved), "R8",
            "output changed during stall", int'(out_valid), 1);
      stall_prev = out_valid && !out_ready;
      saved = {out_is_tok, out_tok, out_i, out_q};
      if (out_valid && out_ready) begin
        if (rd == wr) begin
          chk(0, "R8", "unexpected output item", rd, wr);
        end else begin
          chk(out_is_tok == e_tok[rd], e_req[rd], "item kind", int'(out_is_tok), int'(e_tok[rd]));
          if (e_tok[rd])
            chk(int'(out_tok) == e_w[rd] && out_i == 0 && out_q == 0, e_req[rd], "token word",
                int'(out_tok), e_w[rd]);
          else begin
            chk(int'(out_i) == e_i[rd], e_req[rd], "I value", int'(out_i), e_i[rd]);
            chk(int'(out_q) == e_q[rd], e_req[rd], "Q value", int'(out_q), e_q[rd]);
          end
          rd++;
        end
      end
    end
  end

  task automatic put(input bit c, input logic [7:0] w);
    in_is_ctrl = c;
    in_word = w;
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic expect_data(input logic [3:0] b, input string req);
    int ei, eq;
    case (tb_mode)
      0: begin ei = b[0] ? 64 : -64; eq = 0; end
      1: begin ei = b[0] ? 45 : -45; eq = b[1] ? 45 : -45; end
      default: begin ei = qlev(b[0], b[1]); eq = qlev(b[2], b[3]); end
    endcase
    e_tok[wr] = 0; e_i[wr] = ei; e_q[wr] = eq; e_w[wr] = 0; e_req[wr] = req;
    wr++;
  endtask

  task automatic send_data(input logic [3:0] b, input string req);
    int n;
    n = (tb_mode == 0) ? 1 : (tb_mode == 1) ? 2 : 4;
    expect_data(b, req);
    put(1'b0, {1'b0, 3'(n), b});
  endtask

  task automatic send_mod(input int m);
    put(1'b1, {2'b10, 4'b0000, 2'(m)});
    tb_mode = m;
  endtask

  task automatic send_tok(input logic [7:0] w, input string req);
    e_tok[wr] = 1; e_i[wr] = 0; e_q[wr] = 0; e_w[wr] = int'(w); e_req[wr] = req;
    wr++;
    put(1'b1, w);
  endtask

  task automatic drain(input string req);
    int t = 0;
    while (rd != wr && t < 2000) begin
      @(posedge clk);
      t++;
    end
    #1;
    chk(rd == wr, req, "items received", rd, wr);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(!err_o, "R1", "err_o after reset", int'(err_o), 0);
    chk(in_ready, "R1", "in_ready after reset", int'(in_ready), 1);
    @(posedge clk); #1;
    send_data(4'b0001, "R1");
    send_data(4'b0000, "R1");
    drain("R1");
  endtask

  task automatic t_bpsk;
    send_data(4'b1110, "R3");
    send_data(4'b0001, "R3");
    drain("R3");
  endtask

  task automatic t_qpsk;
    send_mod(1);
    for (int k = 0; k < 4; k++) send_data(4'(k), "R4");
    drain("R4");
  endtask

  task automatic t_qam;
    send_mod(2);
    for (int k = 0; k < 16; k++) send_data(4'(k), "R5");
    drain("R5");
  endtask

  task automatic t_switch;
    send_mod(2);
    send_data(4'b1011, "R6");
    send_mod(0);
    send_data(4'b0001, "R6");
    send_mod(1);
    send_data(4'b0010, "R6");
    send_mod(2);
    send_data(4'b0110, "R6");
    send_mod(0);
    drain("R6");
  endtask

  task automatic t_forward;
    send_tok(8'h3c, "R7");
    send_data(4'b0001, "R7");
    send_tok(8'hc1, "R7");
    send_tok(8'h83, "R2");
    send_data(4'b0000, "R2");
    send_tok(8'h01, "R7");
    drain("R7");
  endtask

  task automatic t_backpressure;
    bp_en = 1;
    send_mod(2);
    for (int k = 0; k < 24; k++) begin
      if (k % 5 == 2) send_tok(8'(8'h40 + k), "R8");
      else send_data(4'(k * 7), "R8");
      if (k == 11) send_mod(1);
    end
    drain("R8");
    bp_en = 0;
    hold_rdy = 1;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic t_latency;
    send_mod(0);
    drain("R9");
    expect_data(4'b0001, "R9");
    in_is_ctrl = 1'b0;
    in_word = 8'h11;
    in_valid = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R9", "output before accept", int'(out_valid), 0);
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid, "R9", "output one cycle after accept", int'(out_valid), 1);
    drain("R9");
    hold_rdy = 0;
    @(posedge clk); #1;
    send_data(4'b0000, "R9");
    send_data(4'b0001, "R9");
    @(negedge clk);
    chk(!in_ready, "R9", "in_ready with two held", int'(in_ready), 0);
    @(posedge clk); #1;
    hold_rdy = 1;
    drain("R9");
  endtask

  task automatic t_err;
    chk(!err_o, "R10", "err_o before mismatch", int'(err_o), 0);
    send_mod(1);
    expect_data(4'b0011, "R10");
    put(1'b0, {1'b0, 3'd4, 4'b0011});
    @(negedge clk);
    chk(err_o, "R10", "err_o after mismatch", int'(err_o), 1);
    send_data(4'b0001, "R10");
    drain("R10");
    chk(err_o, "R10", "err_o stays set", int'(err_o), 1);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1;
    rst_ni = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    mon_en = 1;
    t_reset();
    t_bpsk();
    t_qpsk();
    t_qam();
    t_switch();
    t_forward();
    t_backpressure();
    t_latency();
    t_err();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule